// File: doc/BRIEF.md
# Timestamped Receive Packet Framer

This block wraps a stream of ready-made receive payload bytes into fixed 4096-byte packets. Each packet opens with a 16-byte header and then carries 4080 payload bytes taken in order from the input stream. The header reports two things. The first is the state of the transmit side and the receive FIFO at the moment the packet begins. The second is the value of a free-running 64-bit sample counter, which lets the host line up received data against transmit timing.

The sample counter advances once for every sample strobe while the receiver is enabled, and a clear input forces it to zero. Software is expected to stop streaming while it applies the clear. A packet begins when the framer is idle and the first payload byte is offered. In that cycle the framer takes a snapshot of the counter, the transmit-dropped flag and the FIFO fill code. It then emits the header bytes, followed by the payload.

Both byte streams use valid/ready. A byte moves when valid and ready are high at the same rising edge. The output is a register stage: once `out_valid` is high, `out_data` and `out_last` hold steady until the byte is taken. Because of this stage, back-pressure on the output reaches the input in the same cycle through `in_ready`. A source may drop `in_valid` between bytes without affecting packet content.

Top module: `rx_pkt_framer`

## Requirements
- R1: Every packet is exactly 4096 output bytes, and `out_last` is high on byte 4095 and on no other byte.
- R2: Header byte 0 is {4'b0000, tx_drop, fill[2:0]} (bit 3 the dropped flag, bits 2..0 the fill code); header bytes 1 to 7 are zero.
- R3: The fill code is floor(fifo_occ × 8 / FIFO_DEPTH), saturated at 7 (depth 4096: 511→0, 512→1, 2559→4, 4095→7, 4096→7).
- R4: Header bytes 8 to 15 hold the counter value, most significant byte first. The value is the one held in the cycle where the framer, while idle, first sees `in_valid` for a packet's first payload byte. A strobe in that same cycle is not included.
- R5: The counter increases by exactly one at each clock edge where `rx_en` and `smp_stb` are both high; while `rx_en` is low it does not change.
- R6: `cnt_clr` sets the counter to zero at the next edge and takes priority over a sample strobe.
- R7: Output bytes 16 to 4095 are the accepted input bytes, unchanged and in order; an accepted input byte is presented on the output at the next edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged.
- R9: No input byte is accepted while the header of its packet is still being produced; an accepted byte always lands in slots 16 to 4095.
- R10: After reset `out_valid` and `in_ready` are low and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; gates counting |
| smp_stb | input | 1 | One pulse per received sample |
| cnt_clr | input | 1 | Forces the sample counter to zero |
| tx_drop | input | 1 | Transmit side discarded an expired packet |
| fifo_occ | input | OCC_W | Current receive FIFO occupancy in entries |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Framer takes the payload byte |
| in_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Packet byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
The counter responds one edge after a strobe or a clear. The header snapshot is taken at the edge that ends the idle cycle. The first header byte appears two edges after `in_valid` is first raised, and a payload byte shows up on the output one edge after it is accepted. The bench drives inputs at the falling edge and reads results 1 ns later. In that cycle it decides acceptance from the live `in_ready` and `out_valid`, so each byte is scored at the edge where it actually moves. Expected timestamps come from a count of the strobed edges the bench itself produced, which includes the strobes issued during a packet after the snapshot.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int TS_BITS = 64;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2
  } fr_state_e;

  typedef struct packed {
    logic               drop;
    logic [2:0]         fill;
    logic [TS_BITS-1:0] ts;
  } hdr_snap_t;
endpackage

// File: rtl/rxf_sample_ctr.sv
module rxf_sample_ctr #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         stb,
  output logic [W-1:0] cnt
);
  // clear wins over a strobe in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (en && stb) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/rxf_fill_quant.sv
module rxf_fill_quant #(
  parameter int DEPTH = 4096,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic [OCC_W-1:0] occ,
  output logic [2:0]       code
);
  localparam int SW = OCC_W + 3;
  localparam logic [SW-1:0] DEP = SW'(DEPTH);

  logic [SW-1:0] scaled;
  logic [SW-1:0] quot;

  always_comb begin
    scaled = {occ, 3'b000};
    quot   = scaled / DEP;
    code   = (quot > SW'(7)) ? 3'd7 : quot[2:0];
  end
endmodule

// File: rtl/rxf_hdr_mux.sv
module rxf_hdr_mux
  import rxf_pkg::*;
#(
  parameter int HDR_BYTES = 16,
  parameter int IDX_W     = $clog2(HDR_BYTES)
) (
  input  hdr_snap_t        snap,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       hbyte
);
  localparam int TS_BYTES = TS_BITS / 8;
  localparam int TS_OFS   = HDR_BYTES - TS_BYTES;

  logic [7:0] hdr_arr [HDR_BYTES];

  for (genvar b = 0; b < HDR_BYTES; b++) begin : g_byte
    if (b == 0) begin : g_stat
      assign hdr_arr[b] = {4'b0000, snap.drop, snap.fill};
    end else if (b >= TS_OFS) begin : g_ts
      // most significant byte first
      assign hdr_arr[b] = snap.ts[(TS_BYTES - 1 - (b - TS_OFS)) * 8 +: 8];
    end else begin : g_rsv
      assign hdr_arr[b] = 8'h00;
    end
  end

  assign hbyte = hdr_arr[idx];
endmodule

// File: rtl/rxf_out_stage.sv
module rxf_out_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [7:0] ld_data,
  input  logic       ld_last,
  input  logic       out_ready,
  output logic       free,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_last  <= 1'b0;
    end else if (free) begin
      out_valid <= ld;
      if (ld) begin
        out_data <= ld_data;
        out_last <= ld_last;
      end
    end
  end
endmodule

// File: rtl/rx_pkt_framer.sv
module rx_pkt_framer
  import rxf_pkg::*;
#(
  parameter int PKT_BYTES  = 4096,
  parameter int HDR_BYTES  = 16,
  parameter int FIFO_DEPTH = 4096,
  parameter int OCC_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             smp_stb,
  input  logic             cnt_clr,
  input  logic             tx_drop,
  input  logic [OCC_W-1:0] fifo_occ,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);
  localparam int POS_W = $clog2(PKT_BYTES);
  localparam int IDX_W = $clog2(HDR_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_BYTES - 1);
  localparam logic [POS_W-1:0] HDR_END  = POS_W'(HDR_BYTES - 1);

  fr_state_e        state;
  logic [POS_W-1:0] pos;
  hdr_snap_t        snap;
  logic [TS_BITS-1:0] smp_cnt;
  logic [2:0]       fill_code;
  logic [7:0]       hdr_byte;
  logic             free;
  logic             hdr_go;
  logic             pay_go;
  logic             ld;
  logic [7:0]       ld_data;
  logic             ld_last;

  rxf_sample_ctr #(.W(TS_BITS)) u_ctr (
    .clk (clk),
    .rst_n (rst_n),
    .clr (cnt_clr),
    .en  (rx_en),
    .stb (smp_stb),
    .cnt (smp_cnt)
  );

  rxf_fill_quant #(.DEPTH(FIFO_DEPTH), .OCC_W(OCC_W)) u_fill (
    .occ  (fifo_occ),
    .code (fill_code)
  );

  rxf_hdr_mux #(.HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W)) u_hdr (
    .snap  (snap),
    .idx   (pos[IDX_W-1:0]),
    .hbyte (hdr_byte)
  );

  always_comb begin
    hdr_go   = (state == ST_HDR) && free;
    in_ready = (state == ST_PAY) && free;
    pay_go   = in_ready && in_valid;
    ld       = hdr_go || pay_go;
    ld_data  = (state == ST_HDR) ? hdr_byte : in_data;
    ld_last  = (state == ST_PAY) && (pos == LAST_POS);
  end

  rxf_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (ld),
    .ld_data   (ld_data),
    .ld_last   (ld_last),
    .out_ready (out_ready),
    .free      (free),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pos   <= '0;
      snap  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            snap.drop <= tx_drop;
            snap.fill <= fill_code;
            snap.ts   <= smp_cnt;
            pos       <= '0;
            state     <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (hdr_go) begin
            pos <= pos + POS_W'(1);
            if (pos == HDR_END) state <= ST_PAY;
          end
        end
        ST_PAY: begin
          if (pay_go) begin
            if (pos == LAST_POS) begin
              pos   <= '0;
              state <= ST_IDLE;
            end else begin
              pos <= pos + POS_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int PKT_BYTES = 4096,
  parameter int HDR_BYTES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic        smp_stb,
  input logic        cnt_clr,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_last,
  input logic [63:0] smp_cnt
);
  localparam int POS_W = $clog2(PKT_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_BYTES - 1);
  localparam int TS_OFS = HDR_BYTES - 8;

  logic [POS_W-1:0] beat;
  logic [POS_W:0]   slot;

  always_ff @(posedge clk) begin
    if (!rst_n) beat <= '0;
    else if (out_valid && out_ready) beat <= (beat == LAST_POS) ? '0 : beat + POS_W'(1);
  end

  assign slot = {1'b0, beat} + (POS_W+1)'(out_valid ? 1 : 0);

  a_r1_last_slot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (beat == LAST_POS)));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && beat >= POS_W'(1) && beat < POS_W'(TS_OFS)) |-> (out_data == 8'h00));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && smp_stb && !cnt_clr) |=> (smp_cnt == $past(smp_cnt) + 64'd1));

  a_r5_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !cnt_clr) |=> $stable(smp_cnt));

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (smp_cnt == 64'd0));

  a_r7_pass_next: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r9_payload_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (slot >= (POS_W+1)'(HDR_BYTES) && slot < (POS_W+1)'(PKT_BYTES)));
endmodule

bind rx_pkt_framer rxf_checker #(
  .PKT_BYTES (PKT_BYTES),
  .HDR_BYTES (HDR_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .smp_stb   (smp_stb),
  .cnt_clr   (cnt_clr),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .smp_cnt   (smp_cnt)
);

// File: tb/sim_rx_pkt_framer.sv
`timescale 1ns/1ps
module sim_rx_pkt_framer;
  localparam int PKT   = 4096;
  localparam int HDR   = 16;
  localparam int DEPTH = 4096;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, smp_stb = 1'b0, cnt_clr = 1'b0, tx_drop = 1'b0;
  logic [OCC_W-1:0] fifo_occ = '0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = 8'h00;
  logic out_valid, out_ready = 1'b0, out_last;
  logic [7:0] out_data;

  int checks = 0;
  int fails = 0;
  logic [63:0] model_cnt = 64'd0;

  always #4 clk = ~clk;

  rx_pkt_framer u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .smp_stb(smp_stb), .cnt_clr(cnt_clr),
    .tx_drop(tx_drop), .fifo_occ(fifo_occ), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] fill_of(input int occ);
    int q = (occ * 8) / DEPTH;
    return (q > 7) ? 3'd7 : 3'(q);
  endfunction

  function automatic logic [7:0] pay_of(input int seed, input int i);
    return 8'((i * 7 + seed * 13 + (i >> 8)) & 8'hFF);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10", "out_valid in reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b0, "R10", "in_ready in reset", 64'(in_ready), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    model_cnt = 64'd0;
  endtask

  task automatic tick(input int n, input bit en);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_en = en;
      smp_stb = 1'b1;
      if (en) model_cnt++;
    end
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  // R6: clear asserted together with an enabled strobe
  task automatic clear_ctr();
    @(negedge clk);
    rx_en = 1'b1;
    smp_stb = 1'b1;
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    smp_stb = 1'b0;
    model_cnt = 64'd0;
  endtask

  task automatic run_pkt(input string tag, input int seed, input bit stall, input bit gap,
                         input bit tick_on, input int occ, input bit drop);
    logic [63:0] exp_ts, got_ts;
    logic [7:0] exp0, got0, prev_data;
    int ob = 0, ib = 0, cyc = 0;
    int rsv_err = 0, pay_err = 0, last_err = 0, hold_err = 0, stalls = 0;
    bit prev_stall = 0, timed_out = 0;
    logic prev_last;
    @(negedge clk);
    fifo_occ = OCC_W'(occ);
    tx_drop = drop;
    exp_ts = model_cnt;
    exp0 = {4'b0000, drop, fill_of(occ)};
    got_ts = '0;
    got0 = '0;
    prev_data = '0;
    prev_last = 1'b0;
    while (ob < PKT) begin
      @(negedge clk);
      if (prev_stall) begin
        if (!out_valid || out_data !== prev_data || out_last !== prev_last) hold_err++;
      end
      out_ready = stall ? ((cyc % 3) != 2) : 1'b1;
      in_valid = (gap ? ((cyc % 2) == 0) : 1'b1) && (ib < PKT - HDR);
      in_data = pay_of(seed, ib);
      rx_en = tick_on;
      smp_stb = tick_on;
      if (tick_on) model_cnt++;
      #1;
      prev_stall = out_valid && !out_ready;
      if (prev_stall) stalls++;
      prev_data = out_data;
      prev_last = out_last;
      if (out_valid && out_ready) begin
        if (out_last !== (ob == PKT - 1)) last_err++;
        if (ob == 0) got0 = out_data;
        else if (ob < 8) begin if (out_data !== 8'h00) rsv_err++; end
        else if (ob < HDR) got_ts = {got_ts[55:0], out_data};
        else if (out_data !== pay_of(seed, ob - HDR)) pay_err++;
        ob++;
      end
      if (in_valid && in_ready) ib++;
      cyc++;
      if (cyc > 30000) begin timed_out = 1; break; end
    end
    @(negedge clk);
    in_valid = 1'b0;
    smp_stb = 1'b0;
    out_ready = 1'b1;
    check(!timed_out, "R1", {tag, " packet completes"}, 64'(ob), 64'(PKT));
    check(got0 == exp0, "R2", {tag, " status byte"}, 64'(got0), 64'(exp0));
    check(got0[2:0] == fill_of(occ), "R3", {tag, " fill code"}, 64'(got0[2:0]), 64'(fill_of(occ)));
    check(rsv_err == 0, "R2", {tag, " reserved bytes"}, 64'(rsv_err), 64'd0);
    check(got_ts == exp_ts, "R4", {tag, " timestamp"}, got_ts, exp_ts);
    check(pay_err == 0, "R7", {tag, " payload bytes"}, 64'(pay_err), 64'd0);
    check(last_err == 0, "R1", {tag, " last marker"}, 64'(last_err), 64'd0);
    if (stall) begin
      check(hold_err == 0 && stalls > 0, "R8", {tag, " hold under stall"}, 64'(hold_err), 64'd0);
    end
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", {tag, " no extra byte"}, 64'(out_valid), 64'd0);
    check(in_ready == 1'b0, "R9", {tag, " idle refuses input"}, 64'(in_ready), 64'd0);
  endtask

  initial begin
    #(8.0 * 200000);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R10: counter starts at zero, R3 code 0
    run_pkt("p0_plain", 1, 0, 0, 0, 0, 0);
    // R5: 1000 enabled strobes
    tick(1000, 1'b1);
    run_pkt("p1_stall", 2, 1, 0, 0, 512, 1);
    // R5: strobes with receiver disabled leave counter alone
    tick(300, 1'b0);
    run_pkt("p2_gap", 3, 0, 1, 0, 4095, 0);
    // R4: strobes during a packet do not alter its captured value; R3 saturation
    run_pkt("p3_live", 4, 1, 1, 1, 4096, 1);
    run_pkt("p4_after", 5, 0, 0, 0, 2559, 0);
    run_pkt("p5_edge", 6, 0, 0, 0, 511, 1);
    // R6: clear beats a simultaneous strobe
    tick(77, 1'b1);
    clear_ctr();
    run_pkt("p6_clr", 7, 1, 0, 0, 1024, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule